// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block models the management register set of a Fast Ethernet PHY. A host issues one access per cycle: a strobe, a read/write select, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. Accesses whose PHY address differs from the `PHY_ADDR` parameter are filtered. A matching write can update only the control and advertisement registers. Every read is answered one clock later on a registered data port with a valid flag.

A single `link_up` input drives a two-state link machine. Its states are `LNK_DOWN` and `LNK_UP`. It moves `LNK_DOWN -> LNK_UP` on a clock where `link_up` is high and `LNK_UP -> LNK_DOWN` on a clock where it is low. The state sets the link and autonegotiation-complete status bits and the link-partner ability word.

A second two-state machine produces the read response. Its states are `RSP_IDLE` and `RSP_HOLD`. It enters or stays in `RSP_HOLD` on any read strobe and returns to `RSP_IDLE` on a clock without one. The identifier words come from the `ID_HI` and `ID_LO` parameters.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset `rd_valid` is 0 and `rd_data` is 0x0000. Register 0 (control) reads 0x3100: bit 13 is 100 Mb/s, bit 12 is autonegotiation enable and bit 8 is full duplex. Register 4 (advertisement) reads 0x01E1.
- R2: Register 1 (status) reads 0x7848 while the link is down and 0x786C while it is up. Bit 2 is link up and bit 5 is autonegotiation complete.
- R3: Register 5 (partner ability) reads 0x0080 while the link is down and 0x01E1 while it is up.
- R4: A read issued one clock or more after `link_up` changes returns status and partner words for the new link state.
- R5: A read with `req_phy` different from `PHY_ADDR` returns 0xFFFF. A write with a different address changes no register.
- R6: Registers 2 and 3 read the `ID_HI` and `ID_LO` parameters.
- R7: A write to register 0 with bit 15 clear stores the value. A write to register 4 stores the whole 16-bit value.
- R8: A write to register 0 with bit 15 set stores nothing from the value and restores control to 0x3100 and advertisement to 0x01E1. Control bit 15 never reads back as 1.
- R9: Writes to registers 1, 2, 3, 5 and 6 through 31 have no effect on any readable value.
- R10: Reads of registers 6 through 31 at the matching address return 0x0000.
- R11: `rd_valid` is 1 exactly in the cycle after a read strobe and 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write value |
| link_up | input | 1 | Current link state from the line side |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 16 | Registered read data |

## Verification
A wrong link state shows up at the ports as a status or partner word for the other link state on the first read issued one clock after `link_up` changes. A corrupted control or advertisement register shows up on the next read of register 0 or 4. A response machine left in the wrong state makes `rd_valid` wrong in the cycle right after the access. Sweeping every PHY address against every register number, before writes and after them, catches filtering and decode faults on the first wrong answer.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef enum logic {LNK_DOWN, LNK_UP} link_state_t;
    typedef enum logic {RSP_IDLE, RSP_HOLD} rsp_state_t;

    localparam logic [ADDR_W-1:0] REG_CTRL    = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT    = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ID_HI   = 5'd2;
    localparam logic [ADDR_W-1:0] REG_ID_LO   = 5'd3;
    localparam logic [ADDR_W-1:0] REG_ADV     = 5'd4;
    localparam logic [ADDR_W-1:0] REG_PARTNER = 5'd5;

    // control bits
    localparam logic [DATA_W-1:0] CTRL_SOFT_RST = 16'h8000;
    localparam logic [DATA_W-1:0] CTRL_SPD100   = 16'h2000;
    localparam logic [DATA_W-1:0] CTRL_ANEG_EN  = 16'h1000;
    localparam logic [DATA_W-1:0] CTRL_FDX      = 16'h0100;
    localparam logic [DATA_W-1:0] CTRL_DEFAULT  = CTRL_SPD100 | CTRL_ANEG_EN | CTRL_FDX;

    // status bits
    localparam logic [DATA_W-1:0] STAT_TX_FD    = 16'h4000;
    localparam logic [DATA_W-1:0] STAT_TX_HD    = 16'h2000;
    localparam logic [DATA_W-1:0] STAT_T10_FD   = 16'h1000;
    localparam logic [DATA_W-1:0] STAT_T10_HD   = 16'h0800;
    localparam logic [DATA_W-1:0] STAT_PRE_SUP  = 16'h0040;
    localparam logic [DATA_W-1:0] STAT_ANEG_OK  = 16'h0020;
    localparam logic [DATA_W-1:0] STAT_ANEG_CAP = 16'h0008;
    localparam logic [DATA_W-1:0] STAT_LINK     = 16'h0004;
    localparam logic [DATA_W-1:0] STAT_FIXED    = STAT_TX_FD | STAT_TX_HD | STAT_T10_FD |
                                                  STAT_T10_HD | STAT_PRE_SUP | STAT_ANEG_CAP;
    localparam logic [DATA_W-1:0] STAT_LINKED   = STAT_LINK | STAT_ANEG_OK;

    // ability bits shared by advertisement and partner words
    localparam logic [DATA_W-1:0] ABL_TX_FD  = 16'h0100;
    localparam logic [DATA_W-1:0] ABL_TX     = 16'h0080;
    localparam logic [DATA_W-1:0] ABL_T10_FD = 16'h0040;
    localparam logic [DATA_W-1:0] ABL_T10    = 16'h0020;
    localparam logic [DATA_W-1:0] ABL_SEL    = 16'h0001;
    localparam logic [DATA_W-1:0] ADV_DEFAULT = ABL_TX_FD | ABL_TX | ABL_T10_FD | ABL_T10 | ABL_SEL;
    localparam logic [DATA_W-1:0] PARTNER_DOWN = ABL_TX;
    localparam logic [DATA_W-1:0] PARTNER_UP   = ABL_TX | ABL_TX_FD | ABL_T10_FD | ABL_T10 | ABL_SEL;

    localparam logic [DATA_W-1:0] NO_PHY_WORD = {DATA_W{1'b1}};

endpackage

// File: rtl/phy_link_fsm.sv
module phy_link_fsm
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_in,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] partner_word
);

    link_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LNK_DOWN: state_d = link_in ? LNK_UP : LNK_DOWN;
            LNK_UP:   state_d = link_in ? LNK_UP : LNK_DOWN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LNK_DOWN: begin
                stat_word    = STAT_FIXED;
                partner_word = PARTNER_DOWN;
            end
            LNK_UP: begin
                stat_word    = STAT_FIXED | STAT_LINKED;
                partner_word = PARTNER_UP;
            end
        endcase
    end

    AST_LINK_UP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        link_in |=> (stat_word & STAT_LINKED) == STAT_LINKED); // R4
    AST_LINK_DOWN_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
        !link_in |=> partner_word == PARTNER_DOWN); // R3

endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] adv_q
);

    logic soft_rst;
    assign soft_rst = wr_en && (wr_reg == REG_CTRL) && ((wr_data & CTRL_SOFT_RST) != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEFAULT;
            adv_q  <= ADV_DEFAULT;
        end else if (soft_rst) begin
            ctrl_q <= CTRL_DEFAULT;
            adv_q  <= ADV_DEFAULT;
        end else if (wr_en) begin
            case (wr_reg)
                REG_CTRL: ctrl_q <= wr_data;
                REG_ADV:  adv_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    AST_SOFT_RESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_CTRL && wr_data[15]) |=> (ctrl_q == CTRL_DEFAULT && adv_q == ADV_DEFAULT)); // R8
    AST_CTRL_RST_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[15] == 1'b0); // R8

endmodule

// File: rtl/phy_rsp_fsm.sv
module phy_rsp_fsm
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    rsp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: state_d = rd_strobe ? RSP_HOLD : RSP_IDLE;
            RSP_HOLD: state_d = rd_strobe ? RSP_HOLD : RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rsp_data <= '0;
        else if (rd_strobe) rsp_data <= rd_word;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: rsp_valid = 1'b0;
            RSP_HOLD: rsp_valid = 1'b1;
        endcase
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rsp_valid); // R11
    AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rsp_valid); // R11

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter logic [4:0]  PHY_ADDR = 5'd0,
    parameter logic [15:0] ID_HI    = 16'h2A51,
    parameter logic [15:0] ID_LO    = 16'h6B03
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        link_up,
    output logic        rd_valid,
    output logic [15:0] rd_data
);

    logic              addr_hit;
    logic              wr_en;
    logic              rd_strobe;
    logic [DATA_W-1:0] ctrl_q, adv_q, stat_word, partner_word, rd_word;

    assign addr_hit  = (req_phy == PHY_ADDR);
    assign wr_en     = req_valid && req_write && addr_hit;
    assign rd_strobe = req_valid && !req_write;

    phy_link_fsm u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_in      (link_up),
        .stat_word    (stat_word),
        .partner_word (partner_word)
    );

    phy_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_reg  (req_reg),
        .wr_data (req_wdata),
        .ctrl_q  (ctrl_q),
        .adv_q   (adv_q)
    );

    always_comb begin
        if (!addr_hit) begin
            rd_word = NO_PHY_WORD;
        end else begin
            case (req_reg)
                REG_CTRL:    rd_word = ctrl_q;
                REG_STAT:    rd_word = stat_word;
                REG_ID_HI:   rd_word = ID_HI;
                REG_ID_LO:   rd_word = ID_LO;
                REG_ADV:     rd_word = adv_q;
                REG_PARTNER: rd_word = partner_word;
                default:     rd_word = '0;
            endcase
        end
    end

    phy_rsp_fsm u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .rd_word   (rd_word),
        .rsp_valid (rd_valid),
        .rsp_data  (rd_data)
    );

    AST_FOREIGN_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_phy != PHY_ADDR) |=> rd_data == 16'hFFFF); // R5
    AST_FOREIGN_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_phy != PHY_ADDR) |=> ($stable(ctrl_q) && $stable(adv_q))); // R5
    AST_RO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_reg != REG_CTRL && req_reg != REG_ADV)
        |=> ($stable(ctrl_q) && $stable(adv_q))); // R9

endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

    localparam logic [4:0]  PHY   = 5'd0;
    localparam logic [15:0] IDH   = 16'h2A51;
    localparam logic [15:0] IDL   = 16'h6B03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        link_up = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [15:0] m_ctrl = 16'h3100;
    logic [15:0] m_adv  = 16'h01E1;
    bit          m_link = 1'b0;

    phy_mgmt_regs #(.PHY_ADDR(PHY), .ID_HI(IDH), .ID_LO(IDL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .link_up(link_up), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [4:0] p, input logic [4:0] r);
        if (p != PHY) return 16'hFFFF;
        case (r)
            5'd0:    return m_ctrl;
            5'd1:    return m_link ? 16'h786C : 16'h7848;
            5'd2:    return IDH;
            5'd3:    return IDL;
            5'd4:    return m_adv;
            5'd5:    return m_link ? 16'h01E1 : 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] p, input logic [4:0] r);
        if (p != PHY) return "R5";
        case (r)
            5'd0, 5'd4: return "R7";
            5'd1:       return "R2";
            5'd2, 5'd3: return "R6";
            5'd5:       return "R3";
            default:    return "R10";
        endcase
    endfunction

    task automatic rd(input logic [4:0] p, input logic [4:0] r, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = p; req_reg = r;
        @(negedge clk);
        check("R11", "rd_valid after read", {15'd0, rd_valid}, 16'd1);
        check(tag, $sformatf("read phy %0d reg %0d", p, r), rd_data, model(p, r));
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_phy = p; req_reg = r; req_wdata = d;
        @(negedge clk);
        check("R11", "rd_valid after write", {15'd0, rd_valid}, 16'd0);
        req_valid = 1'b0; req_write = 1'b0;
        if (p == PHY) begin
            if (r == 5'd0) begin
                if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
                else m_ctrl = d;
            end else if (r == 5'd4) begin
                m_adv = d;
            end
        end
    endtask

    task automatic sweep();
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < 32; r++)
                rd(p[4:0], r[4:0], tag_of(p[4:0], r[4:0]));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1", "rd_valid in reset", {15'd0, rd_valid}, 16'd0);
        check("R1", "rd_data in reset", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        rd(PHY, 5'd0, "R1");
        rd(PHY, 5'd4, "R1");
        @(negedge clk);
        check("R11", "rd_valid idle", {15'd0, rd_valid}, 16'd0);

        // link down sweep
        sweep();

        // R4: link rises, next read reflects it
        @(negedge clk); link_up = 1'b1; m_link = 1'b1;
        rd(PHY, 5'd1, "R4");
        rd(PHY, 5'd5, "R4");
        sweep();

        // R7 / R9: write every register
        for (int r = 0; r < 32; r++) wr(PHY, r[4:0], 16'h5A00 | 16'(r));
        rd(PHY, 5'd0, "R7");
        rd(PHY, 5'd4, "R7");
        rd(PHY, 5'd1, "R9");
        rd(PHY, 5'd2, "R9");
        rd(PHY, 5'd3, "R9");
        rd(PHY, 5'd5, "R9");
        rd(PHY, 5'd6, "R9");
        rd(PHY, 5'd31, "R9");
        wr(PHY, 5'd0, 16'h0000);
        rd(PHY, 5'd0, "R7");
        wr(PHY, 5'd4, 16'hFFFF);
        rd(PHY, 5'd4, "R7");

        // R5: foreign writes are dropped
        wr(5'd7, 5'd0, 16'h1234);
        wr(5'd31, 5'd4, 16'h4321);
        rd(PHY, 5'd0, "R5");
        rd(PHY, 5'd4, "R5");

        // R8: soft reset restores defaults
        wr(PHY, 5'd0, 16'h8000);
        rd(PHY, 5'd0, "R8");
        rd(PHY, 5'd4, "R8");
        wr(PHY, 5'd4, 16'h0021);
        wr(PHY, 5'd0, 16'hFFFF);
        rd(PHY, 5'd0, "R8");
        rd(PHY, 5'd4, "R8");
        rd(PHY, 5'd1, "R8");

        // R4: link falls
        @(negedge clk); link_up = 1'b0; m_link = 1'b0;
        rd(PHY, 5'd1, "R4");
        rd(PHY, 5'd5, "R4");
        wr(PHY, 5'd4, 16'h0C01);
        sweep();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule